// File: doc/BRIEF.md
# Paged Nonvolatile Write Buffer Controller

This block is a clocked model of the control logic found inside a bytewide electrically erasable memory. A host drives active-low chip, output and write strobes together with a 16-bit address and an 8-bit data bus. All of these are sampled on the block clock. A write strobe pulse that is long enough loads one byte into a page buffer. The buffer has 128 slots, and the low seven address bits pick the slot. Further loads to the same page keep arriving for as long as each new load begins inside a load window. Once that window lapses with no new load, an internal programming timer runs. At its end, only the loaded bytes are copied into an on-chip byte array.

While programming is in progress, a read returns a status byte instead of array contents. The top data bit of this byte is the inverse of the top bit of the last byte loaded. The bit below it flips on every new read access. A host can therefore poll either bit to learn when the write has finished. All time constants are parameters given in clock cycles. The stored array holds `1 << STORE_PG_W` pages, so only the low page bits address storage. The output data is registered and paired with an enable flag that stands in for a tri-state driver.

Top module: `pgbuf_ctrl`

## Requirements
- R1: After reset the enable flag `dout_en` is 0 and every array byte reads as 0x00.
- R2: A byte load is recognised only while `ce_n`=0, `we_n`=0 and `oe_n`=1 all hold. Holding `oe_n` low or `ce_n` high during a write-enable pulse loads nothing. The address is taken in the first cycle that all three conditions hold, and the data in the last such cycle. This covers both a write-enable-controlled write and a chip-enable-controlled write.
- R3: A write pulse with fewer than NOISE_MIN active cycles is discarded. A pulse with exactly NOISE_MIN active cycles is loaded.
- R4: Address bits [6:0] select the byte within a page and bits [15:7] select the page. Several bytes loaded into one page are all committed by one programming cycle.
- R5: Loaded bytes do not reach the array until the load window closes. The window is LOAD_WIN cycles with no new write start. While the window is open, reads return the old array contents, and a load started inside the window joins the same page.
- R6: Programming lasts PROG_CYC cycles. Reads during that time return status, and after it they return the committed data.
- R7: During programming the status byte has bit 7 equal to the inverse of bit 7 of the last loaded byte, and bits 5:0 equal to 0. Bit 7 shows true data once programming ends.
- R8: During programming, bit 6 of the status byte changes on every new read access. After programming, repeated reads of an address return the same value.
- R9: `dout_en` is 1 in the cycle after one in which `ce_n`=0 and `oe_n`=0, and 0 otherwise. `dout` is 0x00 when no read is active.
- R10: A load whose page field differs from the first load of the pending page is ignored, and the first page is kept.
- R11: Write pulses during programming are ignored. Byte positions that were not loaded keep their previous array values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | 16 | Byte address: page in [15:7], byte in [6:0] |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data or programming status |
| dout_en | output | 1 | Output drive flag, standing in for the tri-state control |

## Verification
The properties assume that the strobes and buses are synchronous to the clock and hold steady from one rising edge to the next. They also assume that two read accesses are separated by at least one cycle in which a strobe is deasserted, since only then does the toggle bit treat a read as new. The stimulus changes every input on the falling clock edge and always releases the chip and output enables between reads. Write pulses are sized in whole cycles, so each one falls clearly above or below the noise threshold. Every load in a page burst starts well inside the window, apart from the deliberate waits that let the window lapse.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } state_e;
endpackage

// File: rtl/pgbuf_strobe.sv
module pgbuf_strobe #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int NOISE_MIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_act,
    output logic              wr_start,
    output logic              wr_done,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_act,
    output logic              rd_start
);
    localparam int NW = $clog2(NOISE_MIN + 1);

    typedef struct packed {
        logic              wr_act;
        logic              rd_act;
        logic [NW-1:0]     lowcnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } strobe_t;

    strobe_t s_d, s_q;

    always_comb begin
        wr_act   = !ce_n && !we_n && oe_n;
        rd_act   = !ce_n && !oe_n;
        wr_start = wr_act && !s_q.wr_act;
        rd_start = rd_act && !s_q.rd_act;
        wr_done  = !wr_act && s_q.wr_act && (s_q.lowcnt >= NW'(NOISE_MIN));
        s_d        = s_q;
        s_d.wr_act = wr_act;
        s_d.rd_act = rd_act;
        if (wr_start) begin
            s_d.addr   = addr;
            s_d.lowcnt = NW'(1);
        end else if (wr_act && (s_q.lowcnt < NW'(NOISE_MIN))) begin
            s_d.lowcnt = s_q.lowcnt + 1'b1;
        end
        if (wr_act) begin
            s_d.data = din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_addr = s_q.addr;
    assign wr_data = s_q.data;
endmodule

// File: rtl/pgbuf_page.sv
module pgbuf_page #(
    parameter int DATA_W = 8,
    parameter int OFS_W  = 7
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             ld_en,
    input  logic [OFS_W-1:0]                 ld_ofs,
    input  logic [DATA_W-1:0]                ld_data,
    input  logic                             clr,
    output logic [(1<<OFS_W)-1:0][DATA_W-1:0] buf_data,
    output logic [(1<<OFS_W)-1:0]            buf_mask
);
    localparam int PB = 1 << OFS_W;

    for (genvar i = 0; i < PB; i++) begin : g_slot
        logic [DATA_W-1:0] data_d, data_q;
        logic              vld_d, vld_q;

        always_comb begin
            data_d = data_q;
            vld_d  = vld_q;
            if (clr) begin
                vld_d = 1'b0;
            end else if (ld_en && (ld_ofs == OFS_W'(i))) begin
                data_d = ld_data;
                vld_d  = 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q <= '0;
                vld_q  <= 1'b0;
            end else begin
                data_q <= data_d;
                vld_q  <= vld_d;
            end
        end

        assign buf_data[i] = data_q;
        assign buf_mask[i] = vld_q;
    end
endmodule

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
    parameter int DATA_W     = 8,
    parameter int OFS_W      = 7,
    parameter int STORE_PG_W = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              commit,
    input  logic [STORE_PG_W-1:0]             commit_pg,
    input  logic [(1<<OFS_W)-1:0][DATA_W-1:0] commit_data,
    input  logic [(1<<OFS_W)-1:0]             commit_mask,
    input  logic [STORE_PG_W+OFS_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]                 rd_data
);
    localparam int PB    = 1 << OFS_W;
    localparam int DEPTH = (1 << STORE_PG_W) * PB;

    logic [DEPTH-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (commit) begin
            for (int i = 0; i < PB; i++) begin
                if (commit_mask[i]) begin
                    mem_d[{commit_pg, OFS_W'(i)}] = commit_data[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/pgbuf_ctrl.sv
module pgbuf_ctrl
    import pgbuf_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int OFS_W      = 7,
    parameter int STORE_PG_W = 2,
    parameter int LOAD_WIN   = 20000,
    parameter int PROG_CYC   = 1000000,
    parameter int NOISE_MIN  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    localparam int PB   = 1 << OFS_W;
    localparam int PG_W = ADDR_W - OFS_W;
    localparam int LW_W = $clog2(LOAD_WIN + 1);
    localparam int PC_W = $clog2(PROG_CYC + 1);

    typedef struct packed {
        state_e            st;
        logic [LW_W-1:0]   win;
        logic [PC_W-1:0]   pcnt;
        logic [PG_W-1:0]   page;
        logic [DATA_W-1:0] last;
        logic              tog;
        logic [DATA_W-1:0] dout;
        logic              den;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic                        wr_act, wr_start, wr_done, rd_act, rd_start;
    logic [ADDR_W-1:0]           wr_addr;
    logic [DATA_W-1:0]           wr_data;
    logic [PG_W-1:0]             wr_page;
    logic                        ld_en, clr, commit;
    logic [PB-1:0][DATA_W-1:0]   buf_data;
    logic [PB-1:0]               buf_mask;
    logic [DATA_W-1:0]           rd_data;

    pgbuf_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NOISE_MIN(NOISE_MIN)) u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .wr_act(wr_act), .wr_start(wr_start),
        .wr_done(wr_done), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_act(rd_act), .rd_start(rd_start)
    );

    pgbuf_page #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_page (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_ofs(wr_addr[OFS_W-1:0]),
        .ld_data(wr_data), .clr(clr), .buf_data(buf_data), .buf_mask(buf_mask)
    );

    pgbuf_store #(.DATA_W(DATA_W), .OFS_W(OFS_W), .STORE_PG_W(STORE_PG_W)) u_store (
        .clk(clk), .rst_n(rst_n), .commit(commit),
        .commit_pg(c_q.page[STORE_PG_W-1:0]), .commit_data(buf_data),
        .commit_mask(buf_mask), .rd_addr(addr[STORE_PG_W+OFS_W-1:0]),
        .rd_data(rd_data)
    );

    assign wr_page = wr_addr[ADDR_W-1:OFS_W];

    always_comb begin
        c_d    = c_q;
        ld_en  = 1'b0;
        clr    = 1'b0;
        commit = 1'b0;
        c_d.den = rd_act;
        case (c_q.st)
            ST_IDLE: begin
                if (wr_done) begin
                    ld_en    = 1'b1;
                    c_d.page = wr_page;
                    c_d.last = wr_data;
                    c_d.win  = '0;
                    c_d.st   = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (wr_start) begin
                    c_d.win = '0;
                end else if (c_q.win < LW_W'(LOAD_WIN)) begin
                    c_d.win = c_q.win + 1'b1;
                end
                if (wr_done && (wr_page == c_q.page)) begin
                    ld_en    = 1'b1;
                    c_d.last = wr_data;
                end
                if (!wr_act && !wr_done && (c_q.win >= LW_W'(LOAD_WIN))) begin
                    c_d.st   = ST_PROG;
                    c_d.pcnt = '0;
                end
            end
            ST_PROG: begin
                c_d.pcnt = c_q.pcnt + 1'b1;
                if (rd_start) begin
                    c_d.tog = ~c_q.tog;
                end
                if (c_q.pcnt == PC_W'(PROG_CYC - 1)) begin
                    commit   = 1'b1;
                    clr      = 1'b1;
                    c_d.pcnt = '0;
                    c_d.st   = ST_IDLE;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
        if (!rd_act) begin
            c_d.dout = '0;
        end else if (c_q.st == ST_PROG) begin
            c_d.dout           = '0;
            c_d.dout[DATA_W-1] = ~c_q.last[DATA_W-1];
            c_d.dout[DATA_W-2] = c_d.tog;
        end else begin
            c_d.dout = rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign dout    = c_q.dout;
    assign dout_en = c_q.den;
endmodule

// File: rtl/pgbuf_chk.sv
module pgbuf_chk
    import pgbuf_pkg::*;
#(
    parameter int PB       = 128,
    parameter int PG_W     = 9,
    parameter int PC_W     = 20,
    parameter int PROG_CYC = 1000000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ce_n,
    input logic            oe_n,
    input logic            dout_en,
    input state_e          st,
    input logic [PB-1:0]   mask,
    input logic [PG_W-1:0] page,
    input logic            tog,
    input logic            rd_start,
    input logic [PC_W-1:0] pcnt
);
    // R9
    den_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n) |=> dout_en);
    // R9
    den_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |=> !dout_en);
    // R5
    idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (mask == '0));
    // R10
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOAD) |=> ((st != ST_LOAD) || $stable(page)));
    // R11
    prog_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG) |=> (((st == ST_PROG) && $stable(mask)) || (mask == '0)));
    // R8
    toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_PROG) && rd_start) |=> (tog != $past(tog)));
    // R6
    prog_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pcnt < PC_W'(PROG_CYC)));
endmodule

bind pgbuf_ctrl pgbuf_chk #(.PB(PB), .PG_W(PG_W), .PC_W(PC_W), .PROG_CYC(PROG_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .dout_en(dout_en),
    .st(c_q.st), .mask(buf_mask), .page(c_q.page), .tog(c_q.tog),
    .rd_start(rd_start), .pcnt(c_q.pcnt)
);

// File: tb/pgbuf_ctrl_tb.sv
`timescale 1ns/1ps
module pgbuf_ctrl_tb;
    localparam int LW = 20;
    localparam int PC = 60;
    localparam int NM = 3;
    localparam int SETTLE = LW + PC + 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [15:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    pgbuf_ctrl #(.LOAD_WIN(LW), .PROG_CYC(PC), .NOISE_MIN(NM)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input int low);
        @(negedge clk);
        addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        repeat (low) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd_exp(input logic [15:0] a, input logic [7:0] e, input string req);
        @(negedge clk);
        addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        @(posedge clk);
        #1;
        exp_q.push_back(e);
        tag_q.push_back(req);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic rd_raw(input logic [15:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        v = dout;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(dout == e, t, dout, e);
            chk(dout_en == 1'b1, "R9 enable during read", dout_en, 1);
        end
    end

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        report();
    end

    initial begin
        logic [7:0] s1, s2, v;
        bit         ok;
        wt(4);
        rst_n = 1'b1;
        wt(2);
        // R1 reset state
        chk(dout_en == 1'b0, "R1 dout_en after reset", dout_en, 0);
        rd_exp(16'h0000, 8'h00, "R1 array cleared");
        rd_exp(16'h01FF, 8'h00, "R1 array cleared top");
        // R9 chip selected, output disabled
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        chk(dout_en == 1'b0, "R9 oe high keeps output off", dout_en, 0);
        chk(dout == 8'h00, "R9 idle dout zero", dout, 0);
        ce_n = 1'b1;

        // R4 R5 page burst in page 1
        wr(16'h0080, 8'hA5, 4);
        rd_exp(16'h0080, 8'h00, "R5 old data while window open");
        wr(16'h0085, 8'h3C, 4);
        wr(16'h00FF, 8'h7E, 4);
        wt(LW + 3);
        rd_raw(16'h00FF, s1);
        rd_raw(16'h00FF, s2);
        chk(s1[7] == 1'b1, "R7 inverted bit7", s1[7], 1);
        chk(s1[5:0] == 6'h00, "R7 low status bits", s1[5:0], 0);
        chk(s1 != 8'h7E, "R6 status while programming", s1, 8'h7E);
        chk(s1[6] != s2[6], "R8 toggle between reads", s2[6], ~s1[6]);
        // R11 write attempt during programming
        wr(16'h0081, 8'h11, 4);
        ok = 0;
        for (int i = 0; i < 100 && !ok; i++) begin
            rd_raw(16'h00FF, v);
            if (v == 8'h7E) ok = 1;
        end
        chk(ok, "R7 polling reaches true data", v, 8'h7E);
        rd_raw(16'h00FF, s1);
        rd_raw(16'h00FF, s2);
        chk(s1 == s2 && s1 == 8'h7E, "R8 no toggle after programming", s2, s1);
        rd_exp(16'h0080, 8'hA5, "R4 byte 0");
        rd_exp(16'h0085, 8'h3C, "R4 byte 5");
        rd_exp(16'h00FF, 8'h7E, "R4 byte 127");
        rd_exp(16'h0081, 8'h00, "R11 unloaded byte and busy write");

        // R10 foreign page in a burst
        wr(16'h0100, 8'h55, 4);
        wr(16'h0180, 8'h66, 4);
        wt(SETTLE);
        rd_exp(16'h0100, 8'h55, "R10 first page kept");
        rd_exp(16'h0180, 8'h00, "R10 other page ignored");

        // R2 inhibits
        @(negedge clk); addr = 16'h0010; din = 8'h99; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
        wt(5);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk); ce_n = 1'b1; we_n = 1'b0;
        wt(5);
        we_n = 1'b1;
        wt(SETTLE);
        rd_exp(16'h0010, 8'h00, "R2 inhibited writes");
        // R2 chip-enable controlled write
        @(negedge clk); addr = 16'h0011; din = 8'h42; oe_n = 1'b1; ce_n = 1'b1; we_n = 1'b0;
        wt(1);
        ce_n = 1'b0;
        wt(4);
        ce_n = 1'b1;
        wt(1);
        we_n = 1'b1;
        wt(SETTLE);
        rd_exp(16'h0011, 8'h42, "R2 chip-enable write");

        // R3 noise threshold
        wr(16'h0012, 8'h77, NM - 1);
        wt(SETTLE);
        rd_exp(16'h0012, 8'h00, "R3 short pulse ignored");
        wr(16'h0013, 8'h88, NM);
        wt(SETTLE);
        rd_exp(16'h0013, 8'h88, "R3 threshold pulse loaded");

        // R5 second load inside the window
        wr(16'h0020, 8'h01, 4);
        wt(10);
        rd_exp(16'h0020, 8'h00, "R5 pending not committed");
        wr(16'h0021, 8'h02, 4);
        wt(SETTLE);
        rd_exp(16'h0020, 8'h01, "R5 first of burst");
        rd_exp(16'h0021, 8'h02, "R5 second of burst");
        rd_exp(16'h0013, 8'h88, "R11 earlier byte untouched");

        wt(4);
        report();
    end
endmodule